// File: doc/BRIEF.md
# Debug Trigger Control Register Bank

This block keeps the software-visible control state for a small set of address/data match triggers inside a processor debug unit. A single CSR-style port selects one of five registers: the trigger index, the control word and compare value of the indexed trigger, an unused third data word, and a read-only capability word. A write updates the addressed register. A read returns its value in the same cycle.

Every control-word write is legalized before it is stored. Only the two match trigger types are accepted. The debug-mode ownership bit is forced low. Unsupported access sizes fall back to "any size". All optional fields that the match logic does not implement are forced to zero. The compare value is stored exactly as written. The control words and compare values of all triggers are driven out continuously as flat vectors for the match comparators. Both the data width (32 or 64) and the trigger count are parameters.

Top module: `dbg_trig_bank`

## Requirements
- R1: Selector code 0 addresses the trigger index. A write there is accepted only when the full written value is below NUM_TRIG; otherwise the index is unchanged. A read returns the index, zero-extended.
- R2: Selector code 1 addresses the control word of the indexed trigger. The type field sits in the top 4 bits (XLEN-1 down to XLEN-4). The debug-mode bit sits at XLEN-5. A write whose type is 2 or 6 is stored with that type and with the debug-mode bit cleared.
- R3: A control write whose type is neither 2 nor 6 leaves every trigger's control word unchanged.
- R4: In a stored control word, only these bits may be nonzero: the type field, bits 0 (load), 1 (store), 2 (execute), 3 (U), 4 (S) and 6 (M), and the size bits named in R5 and R6. These bits are kept as written. Every other bit reads zero.
- R5: For type 2, the size code is bits 17:16, with bits 22:21 as its upper half when XLEN is 64 (for XLEN 32, bits 22:21 are forced to zero). Codes 0, 1, 2, 3 and 5 (any, 1, 2, 4 and 8 bytes) are kept; any other code is stored as 0. Bits 24:23 are forced to zero for type 2.
- R6: For type 6, the size code is bits 19:16, with the same legal set as R5; an illegal code is stored as 0. Bits 23 (VU) and 24 (VS) are kept as written.
- R7: Selector code 4 reads 0x44 (bits 2 and 6 set). Writes to it have no effect.
- R8: After reset, the index is 0, every control word holds type 2 with all other bits zero, and every compare value is zero.
- R9: Selector code 3 always reads zero and writes to it are ignored. Codes 5 to 7 read zero and writes to them are ignored.
- R10: Selector code 2 stores the full written value into the compare value of the indexed trigger without any checking.
- R11: Read data depends combinationally on the selector in the same cycle. A write becomes visible after the next rising clock edge. Trigger i occupies bits [i*XLEN +: XLEN] of both output vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| csrSel | input | 3 | Register selector (0 index, 1 control, 2 compare, 3 unused, 4 capability) |
| csrWe | input | 1 | Write enable for the selected register |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data of the selected register |
| trigCtrl | output | NUM_TRIG*XLEN | Control words of all triggers |
| trigCmp | output | NUM_TRIG*XLEN | Compare values of all triggers |

## Verification
Reads are due in the same cycle the selector is applied, so the bench changes the selector at a falling edge and samples the read data one nanosecond later. A write is due after exactly one rising edge. The bench holds the write for one edge, samples one nanosecond after that edge, and only then updates its reference model. Each check therefore compares the register state produced by all earlier writes against a model that has applied the same writes in the same order.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [2:0] {
    SEL_INDEX  = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_CMP    = 3'd2,
    SEL_SPARE  = 3'd3,
    SEL_CAPS   = 3'd4
  } csr_sel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrCmp;
  } trig_strobe_t;

  localparam logic [3:0] TYPE_MATCH  = 4'd2;
  localparam logic [3:0] TYPE_MATCH6 = 4'd6;
  localparam int         CAPS_VALUE  = (1 << 2) | (1 << 6);

  function automatic logic sizeLegal(input logic [3:0] code);
    return (code == 4'd0) || (code == 4'd1) || (code == 4'd2) ||
           (code == 4'd3) || (code == 4'd5);
  endfunction

endpackage

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       csrSel,
  input  logic             csrWe,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [IDX_W-1:0] curIdx,
  output trig_strobe_t     strobe
);

  localparam logic [XLEN-1:0] IDX_LIMIT = XLEN'(NUM_TRIG);

  csr_sel_e selDec;
  logic     idxWrite;

  assign selDec   = csr_sel_e'(csrSel);
  assign idxWrite = csrWe && (selDec == SEL_INDEX) && (csrWdata < IDX_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curIdx <= '0;
    end else if (idxWrite) begin
      curIdx <= csrWdata[IDX_W-1:0];
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.wrCtrl = csrWe && (selDec == SEL_CTRL);
    strobe.wrCmp  = csrWe && (selDec == SEL_CMP);
  end

endmodule

// File: rtl/dbg_trig_legal.sv
module dbg_trig_legal
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rawVal,
  output logic            accept,
  output logic [XLEN-1:0] legalVal
);

  localparam bit HAS_SIZE_HI = (XLEN == 64);

  logic [3:0] wType;
  logic [3:0] sizeT2;
  logic [3:0] sizeT6;

  assign wType  = rawVal[XLEN-1 -: 4];
  assign accept = (wType == TYPE_MATCH) || (wType == TYPE_MATCH6);
  assign sizeT6 = rawVal[19:16];

  generate
    if (HAS_SIZE_HI) begin : gSizeWide
      assign sizeT2 = {rawVal[22:21], rawVal[17:16]};
    end else begin : gSizeNarrow
      assign sizeT2 = {2'b00, rawVal[17:16]};
    end
  endgenerate

  always_comb begin
    legalVal              = '0;
    legalVal[XLEN-1 -: 4] = wType;
    legalVal[4:0]         = rawVal[4:0];
    legalVal[6]           = rawVal[6];
    if (wType == TYPE_MATCH6) begin
      legalVal[24:23] = rawVal[24:23];
      if (sizeLegal(sizeT6)) begin
        legalVal[19:16] = sizeT6;
      end
    end else if (sizeLegal(sizeT2)) begin
      legalVal[17:16] = sizeT2[1:0];
      if (HAS_SIZE_HI) begin
        legalVal[22:21] = sizeT2[3:2];
      end
    end
  end

endmodule

// File: rtl/dbg_trig_data.sv
module dbg_trig_data
  import dbg_trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  trig_strobe_t             strobe,
  input  logic [IDX_W-1:0]         curIdx,
  input  logic [2:0]               csrSel,
  input  logic [XLEN-1:0]          csrWdata,
  output logic [XLEN-1:0]          csrRdata,
  output logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  output logic [NUM_TRIG*XLEN-1:0] trigCmp
);

  localparam logic [XLEN-1:0] CTRL_RESET = {TYPE_MATCH, {(XLEN-4){1'b0}}};

  logic            accept;
  logic [XLEN-1:0] legalVal;
  logic [XLEN-1:0] ctrlArr [NUM_TRIG];
  logic [XLEN-1:0] cmpArr  [NUM_TRIG];

  dbg_trig_legal #(.XLEN(XLEN)) uLegal (
    .rawVal   (csrWdata),
    .accept   (accept),
    .legalVal (legalVal)
  );

  generate
    for (genvar i = 0; i < NUM_TRIG; i++) begin : gTrig
      logic hit;
      assign hit = (curIdx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctrlArr[i] <= CTRL_RESET;
          cmpArr[i]  <= '0;
        end else begin
          if (strobe.wrCtrl && accept && hit) begin
            ctrlArr[i] <= legalVal;
          end
          if (strobe.wrCmp && hit) begin
            cmpArr[i] <= csrWdata;
          end
        end
      end

      assign trigCtrl[i*XLEN +: XLEN] = ctrlArr[i];
      assign trigCmp[i*XLEN +: XLEN]  = cmpArr[i];
    end
  endgenerate

  always_comb begin
    case (csr_sel_e'(csrSel))
      SEL_INDEX: csrRdata = XLEN'(curIdx);
      SEL_CTRL:  csrRdata = ctrlArr[curIdx];
      SEL_CMP:   csrRdata = cmpArr[curIdx];
      SEL_CAPS:  csrRdata = XLEN'(CAPS_VALUE);
      default:   csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dbg_trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               csrSel,
  input  logic                     csrWe,
  input  logic [XLEN-1:0]          csrWdata,
  output logic [XLEN-1:0]          csrRdata,
  output logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  output logic [NUM_TRIG*XLEN-1:0] trigCmp
);

  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [IDX_W-1:0] curIdx;
  trig_strobe_t     strobe;

  dbg_trig_ctrl #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csrSel   (csrSel),
    .csrWe    (csrWe),
    .csrWdata (csrWdata),
    .curIdx   (curIdx),
    .strobe   (strobe)
  );

  dbg_trig_data #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .curIdx   (curIdx),
    .csrSel   (csrSel),
    .csrWdata (csrWdata),
    .csrRdata (csrRdata),
    .trigCtrl (trigCtrl),
    .trigCmp  (trigCmp)
  );

endmodule

// File: rtl/dbg_trig_check.sv
module dbg_trig_check #(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  parameter int IDX_W    = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               csrSel,
  input logic                     csrWe,
  input logic [XLEN-1:0]          csrWdata,
  input logic [XLEN-1:0]          csrRdata,
  input logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input logic [NUM_TRIG*XLEN-1:0] trigCmp,
  input logic [IDX_W-1:0]         curIdx
);

  localparam logic [XLEN-1:0] KEEP_MASK =
      {4'hF, {(XLEN-4){1'b0}}} | XLEN'(32'h01EF_005F);

  logic [3:0] wType;
  assign wType = csrWdata[XLEN-1 -: 4];

  // R1: index never leaves range, out-of-range writes do not move it
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(curIdx) < NUM_TRIG);
  a_r1_idx_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (csrWe && csrSel == 3'd0 && csrWdata >= XLEN'(NUM_TRIG)) |=> $stable(curIdx));

  // R3: rejected type leaves all control words alone
  a_r3_bad_type_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (csrWe && csrSel == 3'd1 && wType != 4'd2 && wType != 4'd6) |=> $stable(trigCtrl));

  // R7 and R9: constant read views
  a_r7_caps_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csrSel == 3'd4) |-> csrRdata == XLEN'(32'h44));
  a_r9_spare_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csrSel == 3'd3) |-> csrRdata == '0);

  generate
    for (genvar i = 0; i < NUM_TRIG; i++) begin : gChk
      logic [XLEN-1:0] ctrlW;
      assign ctrlW = trigCtrl[i*XLEN +: XLEN];

      // R2
      a_r2_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ctrlW[XLEN-1 -: 4] == 4'd2 || ctrlW[XLEN-1 -: 4] == 4'd6);
      a_r2_dmode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrlW[XLEN-5] == 1'b0);
      // R4
      a_r4_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrlW & ~KEEP_MASK) == '0);
      // R5
      a_r5_type2_no_vbits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrlW[XLEN-1 -: 4] == 4'd2) |-> ctrlW[24:23] == 2'b00);
      // R10
      a_r10_cmp_store: assert property (@(posedge clk) disable iff (!rst_n)
        (csrWe && csrSel == 3'd2 && curIdx == IDX_W'(i)) |=>
          trigCmp[i*XLEN +: XLEN] == $past(csrWdata));
    end
  endgenerate

endmodule

bind dbg_trig_bank dbg_trig_check #(
  .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)
) uCheck (
  .clk      (clk),
  .rst_n    (rst_n),
  .csrSel   (csrSel),
  .csrWe    (csrWe),
  .csrWdata (csrWdata),
  .csrRdata (csrRdata),
  .trigCtrl (trigCtrl),
  .trigCmp  (trigCmp),
  .curIdx   (curIdx)
);

// File: tb/dbg_trig_bank_test.sv
module dbg_trig_bank_test;

  localparam int XLEN     = 32;
  localparam int NUM_TRIG = 2;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [2:0]               csrSel = 3'd0;
  logic                     csrWe = 1'b0;
  logic [XLEN-1:0]          csrWdata = '0;
  logic [XLEN-1:0]          csrRdata;
  logic [NUM_TRIG*XLEN-1:0] trigCtrl;
  logic [NUM_TRIG*XLEN-1:0] trigCmp;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mCtrl [NUM_TRIG];
  logic [31:0] mCmp  [NUM_TRIG];
  int          mIdx;

  dbg_trig_bank #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) uut (
    .clk(clk), .rst_n(rst_n), .csrSel(csrSel), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .trigCtrl(trigCtrl), .trigCmp(trigCmp)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] expCtrl(input logic [31:0] w, input logic [31:0] old);
    logic [3:0]  t;
    logic [31:0] r;
    t = w[31:28];
    if (t != 4'd2 && t != 4'd6) return old;
    r = {t, 28'h0} | (w & 32'h0000_005F);
    if (t == 4'd6) begin
      r[24:23] = w[24:23];
      if (w[19:16] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}) r[19:16] = w[19:16];
    end else begin
      r[17:16] = w[17:16];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic csrWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    csrSel = sel; csrWe = 1'b1; csrWdata = data;
    @(posedge clk);
    #1;
    csrWe = 1'b0;
    case (sel)
      3'd0: if (data < NUM_TRIG) mIdx = int'(data);
      3'd1: mCtrl[mIdx] = expCtrl(data, mCtrl[mIdx]);
      3'd2: mCmp[mIdx] = data;
      default: ;
    endcase
  endtask

  task automatic readCheck(input string req, input logic [2:0] sel, input logic [31:0] exp);
    @(negedge clk);
    csrSel = sel; csrWe = 1'b0;
    #1;
    check(req, csrRdata, exp);
  endtask

  task automatic checkAll();
    readCheck("R1 index read", 3'd0, 32'(mIdx));
    readCheck("R2 control read", 3'd1, mCtrl[mIdx]);
    readCheck("R10 compare read", 3'd2, mCmp[mIdx]);
    for (int i = 0; i < NUM_TRIG; i++) begin
      check("R11 ctrl vector", trigCtrl[i*XLEN +: XLEN], mCtrl[i]);
      check("R11 cmp vector", trigCmp[i*XLEN +: XLEN], mCmp[i]);
    end
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_TRIG; i++) begin
      mCtrl[i] = 32'h2000_0000;
      mCmp[i]  = '0;
    end
    mIdx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset state
    for (int i = 0; i < NUM_TRIG; i++) begin
      check("R8 reset ctrl", trigCtrl[i*XLEN +: XLEN], 32'h2000_0000);
      check("R8 reset cmp", trigCmp[i*XLEN +: XLEN], 32'h0);
    end
    readCheck("R8 reset index", 3'd0, 32'h0);

    // R1 index bounds
    csrWrite(3'd0, 32'd2);
    readCheck("R1 limit ignored", 3'd0, 32'd0);
    csrWrite(3'd0, 32'd1);
    readCheck("R1 accepted", 3'd0, 32'd1);
    csrWrite(3'd0, 32'hFFFF_FFFF);
    readCheck("R1 large ignored", 3'd0, 32'd1);

    // R2/R4/R5 type 2 all ones
    csrWrite(3'd1, 32'h2FFF_FFFF);
    readCheck("R2 R4 R5 type2 legal", 3'd1, 32'h2003_005F);
    // R6 type 6 illegal size, V bits kept
    csrWrite(3'd1, 32'h6FFF_FFFF);
    readCheck("R6 type6 illegal size", 3'd1, 32'h6180_005F);
    csrWrite(3'd1, 32'h6005_0004);
    readCheck("R6 type6 size 5 kept", 3'd1, 32'h6005_0004);
    csrWrite(3'd1, 32'h6004_0001);
    readCheck("R6 type6 size 4 dropped", 3'd1, 32'h6000_0001);
    // R3 bad types
    csrWrite(3'd1, 32'h0FFF_FFFF);
    readCheck("R3 type0 ignored", 3'd1, 32'h6000_0001);
    csrWrite(3'd1, 32'h3000_0007);
    readCheck("R3 type3 ignored", 3'd1, 32'h6000_0001);
    // R10 compare
    csrWrite(3'd2, 32'hDEAD_BEEF);
    readCheck("R10 compare raw", 3'd2, 32'hDEAD_BEEF);
    // R7 / R9
    csrWrite(3'd4, 32'hFFFF_FFFF);
    readCheck("R7 caps", 3'd4, 32'h44);
    csrWrite(3'd3, 32'hFFFF_FFFF);
    readCheck("R9 spare zero", 3'd3, 32'h0);
    csrWrite(3'd5, 32'hFFFF_FFFF);
    readCheck("R9 unused code zero", 3'd5, 32'h0);
    checkAll();

    // random mix, R1 R2 R3 R4 R5 R6 R10 R11
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  s;
      logic [31:0] d;
      s = 3'($urandom % 6);
      d = $urandom;
      if (s == 3'd0) d = (($urandom % 4) == 0) ? d : 32'($urandom % 3);
      if (s == 3'd1) begin
        case ($urandom % 3)
          0: d[31:28] = 4'd2;
          1: d[31:28] = 4'd6;
          default: ;
        endcase
      end
      csrWrite(s, d);
      checkAll();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule